// File: doc/BRIEF.md
# Mode-Selectable Bit-Length SPI Master

This block drives one SPI slave as bus master. A transfer moves any number of bits from zero up to the width of the length field. The count need not be a multiple of eight. Each bit goes out on MOSI while a bit is taken in from MISO. The clock polarity and phase, the half-period length, the bit count and two chip-select flags are read from configuration inputs in the cycle a start request is accepted. They are then held for the whole transfer, so the inputs may change freely once the block reports busy.

Outgoing data is pulled one byte at a time from a byte source. The block pulses a pop strobe in the cycle it consumes the byte present on `tx_data`. Incoming data leaves as bytes with a one-cycle valid strobe. A short final byte is left-justified. The begin flag decides whether chip select is driven low when the transfer opens. The end flag decides whether chip select is released when it closes. A long transaction can therefore be built from several transfers while chip select stays low. MISO passes through a two-flop synchroniser, and each sample is taken late by exactly that delay.

Top module: `spim_master`

## Requirements
- R1: After reset `cs_n` is 1 and `busy`, `done`, `rx_valid` are 0. While idle, `sck` follows `cfg_cpol` one cycle later.
- R2: `start` is accepted only when `busy` is 0. A `start` pulse given during a transfer changes neither that transfer nor the cycles that follow it.
- R3: A transfer opens with one half period of `sck` at CPOL. Every half period lasts `cfg_div`+1 clock cycles, so sampling edges are 2·(`cfg_div`+1) cycles apart.
- R4: With CPHA=0, each bit starts by driving `sck` to the inverse of CPOL while presenting the bit on MOSI. MISO is sampled when `sck` returns to CPOL.
- R5: With CPHA=1, each bit starts with `sck` at CPOL while presenting the bit on MOSI. MISO is sampled when `sck` goes to the inverse of CPOL, and `sck` goes back to CPOL after the last bit.
- R6: Bits leave MSB first. `tx_pop` pulses once before bit 0 and once before every bit whose index is a multiple of 8, and the byte on `tx_data` is taken in that cycle. A transfer of N bits makes ceil(N/8) pops.
- R7: Each group of 8 received bits is delivered on `rx_data` with a one-cycle `rx_valid`. The first received bit is the MSB.
- R8: When N mod 8 = r ≠ 0, the last delivered byte holds the final r bits in bits 7 down to 8−r, and its low 8−r bits are 0.
- R9: `cs_n` falls when a transfer opens only if `cfg_begin` is 1. It rises at the close only if `cfg_end` is 1. Otherwise it keeps its level, and it never changes in the middle of a transfer.
- R10: MISO passes through a two-flop synchroniser. The value delivered for each bit is the MISO level just before that bit's sampling edge.
- R11: `done` pulses for one cycle as `busy` falls. A zero-length transfer still applies the chip-select flags and raises `done`, with no `sck` edge, no `tx_pop` and no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (taken when idle) |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | DIV_W | Half period minus one, in clock cycles |
| cfg_bits | input | LEN_W | Number of bits to transfer |
| cfg_begin | input | 1 | Assert chip select at the start |
| cfg_end | input | 1 | Release chip select at the end |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_data | input | 8 | Next outgoing byte |
| tx_pop | output | 1 | `tx_data` consumed this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` valid this cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
The assertions check the cycle-level rules on every cycle. These are: `sck` moves only when a half period expires, chip select holds steady inside a transfer, the idle clock follows CPOL, the popped byte's MSB appears on MOSI, a short byte has zero padding, and `done` is a lone pulse outside `busy`. Some properties can only be shown by the bench's scenarios. These are that MOSI carries the right bit stream on the correct edge in all four modes, that received bytes match what a slave put on MISO, that pop and edge counts match the bit count, and that chip select persists correctly across chained and zero-length transfers.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PHA,
    ST_PHB,
    ST_FLUSH
  } spim_state_e;

  // sck level in the first half of a bit (MOSI launch half)
  function automatic logic lvl_launch(input logic cpol, input logic cpha);
    return cpol ^ ~cpha;
  endfunction

  // sck level in the second half of a bit, entered on the sampling edge
  function automatic logic lvl_sample(input logic cpol, input logic cpha);
    return cpol ^ cpha;
  endfunction

  // Move nb collected bits (0 means a full byte) to the top of the byte
  function automatic logic [7:0] ljust(input logic [7:0] b, input logic [2:0] nb);
    return (nb == 3'd0) ? b : (b << (4'd8 - {1'b0, nb}));
  endfunction

  // Mask of the padding bits that a short byte of nb bits must leave at zero
  function automatic logic [7:0] pad_mask(input logic [2:0] nb);
    return 8'hFF >> nb;
  endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [DIV_W-1:0] div,
  output logic             expire
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (reload)         cnt_q <= div;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  // R3
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reload) && $past(cnt_q) == '0) |-> cnt_q == '0);

endmodule

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q[0] <= 1'b0;
    else        ff_q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q[g] <= 1'b0;
      else        ff_q[g] <= ff_q[g-1];
    end
  end

  assign q = ff_q[STAGES-1];

  // R10
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ff_q[0] == $past(d));

endmodule

// File: rtl/spim_rxpack.sv
module spim_rxpack import spim_pkg::*; #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap,
  input  logic             din,
  input  logic [LEN_W-1:0] bits,
  output logic [7:0]       rx_data,
  output logic             rx_valid
);

  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       sh_q;
  logic             part_q;
  logic [2:0]       rem_q;

  logic [LEN_W-1:0] cnt_nx;
  logic [7:0]       sh_nx;
  logic             byte_full;
  logic             byte_tail;

  assign cnt_nx    = cnt_q + 1'b1;
  assign sh_nx     = {sh_q[6:0], din};
  assign byte_full = (cnt_nx[2:0] == 3'd0);
  assign byte_tail = (cnt_nx == bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      part_q   <= 1'b0;
      rem_q    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (clear) begin
      cnt_q    <= '0;
      rx_valid <= 1'b0;
    end else if (cap) begin
      sh_q     <= sh_nx;
      cnt_q    <= cnt_nx;
      rx_valid <= byte_full || byte_tail;
      rx_data  <= ljust(sh_nx, cnt_nx[2:0]);
      part_q   <= !byte_full;
      rem_q    <= cnt_nx[2:0];
    end else begin
      rx_valid <= 1'b0;
    end
  end

  // R8
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && part_q) |-> (rx_data & pad_mask(rem_q)) == 8'h00);

  // R7
  full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !part_q) |-> cnt_q[2:0] == 3'd0);

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/spim_master.sv
module spim_master import spim_pkg::*; #(
  parameter int DIV_W       = 8,
  parameter int LEN_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_bits,
  input  logic             cfg_begin,
  input  logic             cfg_end,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);

  spim_state_e      state_q;
  logic             cpol_q, cpha_q, end_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] bits_q;
  logic [LEN_W-1:0] bit_idx_q;
  logic [7:0]       tx_sh_q;
  logic [SYNC_STAGES-1:0] smp_pipe_q;
  logic             sck_q, cs_n_q, done_q;

  // named internal events
  logic             tmr_expire;
  logic             tmr_reload;
  logic             go;
  logic             last_bit;
  logic             enter_a;
  logic             enter_b;
  logic             enter_flush;
  logic             finish;
  logic             miso_s;
  logic             rx_cap;
  logic [LEN_W-1:0] nxt_idx;

  assign go          = (state_q == ST_IDLE) && start;
  assign last_bit    = (bit_idx_q == bits_q - 1'b1);
  assign nxt_idx     = (state_q == ST_LEAD) ? '0 : bit_idx_q + 1'b1;
  assign enter_a     = tmr_expire && ((state_q == ST_LEAD && bits_q != '0) ||
                                      (state_q == ST_PHB  && !last_bit));
  assign enter_b     = tmr_expire && (state_q == ST_PHA);
  assign enter_flush = tmr_expire && ((state_q == ST_LEAD && bits_q == '0) ||
                                      (state_q == ST_PHB  && last_bit));
  assign finish      = (state_q == ST_FLUSH) && (smp_pipe_q == '0);
  assign tmr_reload  = go || enter_a || enter_b;
  assign tx_pop      = enter_a && (nxt_idx[2:0] == 3'd0);
  assign rx_cap      = smp_pipe_q[SYNC_STAGES-1];

  spim_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (tmr_reload),
    .div    (go ? cfg_div : div_q),
    .expire (tmr_expire)
  );

  spim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (miso),
    .q     (miso_s)
  );

  spim_rxpack #(.LEN_W(LEN_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .cap      (rx_cap),
    .din      (miso_s),
    .bits     (bits_q),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      end_q      <= 1'b0;
      div_q      <= '0;
      bits_q     <= '0;
      bit_idx_q  <= '0;
      tx_sh_q    <= '0;
      smp_pipe_q <= '0;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      done_q     <= finish;
      smp_pipe_q <= {smp_pipe_q[SYNC_STAGES-2:0], enter_b};
      case (state_q)
        ST_IDLE: begin
          sck_q <= cfg_cpol;
          if (start) begin
            cpol_q  <= cfg_cpol;
            cpha_q  <= cfg_cpha;
            div_q   <= cfg_div;
            bits_q  <= cfg_bits;
            end_q   <= cfg_end;
            state_q <= ST_LEAD;
            if (cfg_begin) cs_n_q <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (enter_a)          state_q <= ST_PHA;
          else if (enter_flush) state_q <= ST_FLUSH;
        end
        ST_PHA: begin
          if (enter_b) state_q <= ST_PHB;
        end
        ST_PHB: begin
          if (enter_a)          state_q <= ST_PHA;
          else if (enter_flush) state_q <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (finish) begin
            state_q <= ST_IDLE;
            if (end_q) cs_n_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (enter_a) begin
        bit_idx_q <= nxt_idx;
        sck_q     <= lvl_launch(cpol_q, cpha_q);
        tx_sh_q   <= tx_pop ? tx_data : {tx_sh_q[6:0], 1'b0};
      end
      if (enter_b)     sck_q <= lvl_sample(cpol_q, cpha_q);
      if (enter_flush) sck_q <= cpol_q;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign sck  = sck_q;
  assign cs_n = cs_n_q;
  assign mosi = tx_sh_q[7];

  // R1
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> sck == $past(cfg_cpol));

  // R3
  sck_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$stable(sck)) |-> $past(tmr_expire));

  // R9
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));

  // R6
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (state_q == ST_PHA && mosi == $past(tx_data[7])));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(bits_q));

endmodule

// File: tb/test_spim_master.sv
module test_spim_master;
  localparam int DIV_W = 3;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [LEN_W-1:0] cfg_bits = '0;
  logic             cfg_begin = 1'b0, cfg_end = 1'b0;
  logic             busy, done, tx_pop, rx_valid, sck, mosi, cs_n;
  logic [7:0]       tx_data, rx_data;
  logic             miso;

  always #10 clk = ~clk;

  spim_master #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_spim_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_bits(cfg_bits), .cfg_begin(cfg_begin), .cfg_end(cfg_end),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_valid(rx_valid), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tx_fn(input int k);
    return 8'((k * 37 + 91) % 256);
  endfunction

  function automatic logic miso_fn(input int i);
    return ((i * 13 + 5) % 7) > 2;
  endfunction

  // byte source
  int tx_ptr = 0;
  always @(posedge clk) if (tx_pop) tx_ptr <= tx_ptr + 1;
  assign tx_data = tx_fn(tx_ptr);

  // slave model: presents bit slv_idx, advances after each sampling edge
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  int   slv_idx = 0;
  logic mosi_got [0:63];
  int   n_smp = 0, last_smp = 0, gap_exp = 2, bad_gap = 0, edge_cnt = 0;
  assign miso = miso_fn(slv_idx);

  always @(negedge cs_n) slv_idx = 0;

  always @(sck) begin
    if (busy) edge_cnt++;
    if (!cs_n && sck == (m_cpol ^ m_cpha)) begin
      if (n_smp < 64) mosi_got[n_smp] = mosi;
      if (n_smp > 0 && (cyc - last_smp) != gap_exp) bad_gap++;
      last_smp = cyc;
      n_smp++;
      slv_idx++;
    end
  end

  // sinks
  logic [7:0] rx_got [0:15];
  int n_rx = 0, n_pop = 0, n_done = 0, cs_low = 0;
  always @(negedge clk) begin
    if (rx_valid) begin
      if (n_rx < 16) rx_got[n_rx] = rx_data;
      n_rx++;
    end
    if (tx_pop) n_pop++;
    if (done) n_done++;
    if (!cs_n) cs_low++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic cpol, input logic cpha, input int div, input int len,
                          input logic beg, input logic fin, input bit poke);
    int tx_base, rx_base, guard, nbytes, bad_tx, bad_rx;
    bit active;
    @(negedge clk);
    active   = beg || !cs_n;
    rx_base  = beg ? 0 : slv_idx;
    tx_base  = tx_ptr;
    m_cpol   = cpol; m_cpha = cpha;
    cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_div  = DIV_W'(div); cfg_bits = LEN_W'(len);
    cfg_begin = beg; cfg_end = fin;
    @(negedge clk);
    n_smp = 0; n_rx = 0; n_pop = 0; n_done = 0; edge_cnt = 0; bad_gap = 0; cs_low = 0;
    gap_exp = 2 * (div + 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 4) begin
        start = 1'b1; cfg_bits = LEN_W'(len + 7); cfg_cpha = ~cpha;
      end else if (poke && guard == 5) begin
        start = 1'b0;
      end
    end
    chk(done === 1'b1 && busy === 1'b0, "R11 done with busy low", int'(busy), 0);
    nbytes = (len + 7) / 8;
    if (active) begin
      bad_tx = 0;
      for (int j = 0; j < len; j++) begin
        logic [7:0] tb;
        tb = tx_fn(tx_base + j / 8);
        if (mosi_got[j] !== tb[7 - (j % 8)]) bad_tx++;
      end
      chk(bad_tx == 0 && n_smp == len, cpha ? "R5 R6 mosi stream" : "R4 R6 mosi stream", n_smp - bad_tx, len);
      chk(bad_gap == 0, "R3 sampling edge spacing", bad_gap, 0);
      bad_rx = 0;
      for (int k = 0; k < nbytes; k++) begin
        int nb, v;
        nb = (k == nbytes - 1 && (len % 8) != 0) ? len % 8 : 8;
        v = 0;
        for (int b = 0; b < nb; b++) v = (v << 1) | int'(miso_fn(rx_base + k * 8 + b));
        v = (v << (8 - nb)) & 255;
        if (k < 16 && int'(rx_got[k]) != v) begin
          bad_rx++;
          $display("FAIL R7 R8 R10 rx byte %0d actual=%0h expected=%0h", k, rx_got[k], v);
        end
      end
      chk(bad_rx == 0 && n_rx == nbytes, "R7 R8 R10 received bytes", n_rx, nbytes);
    end else begin
      chk(n_smp == 0 && cs_low == 0, "R9 no select without begin", cs_low, 0);
    end
    chk(n_pop == nbytes, "R6 pop count", n_pop, nbytes);
    chk(edge_cnt == 2 * len, "R11 R4 R5 sck edge count", edge_cnt, 2 * len);
    repeat (6) @(negedge clk);
    chk(n_done == 1 && busy == 1'b0, "R2 R11 single completion", n_done, 1);
    chk(sck == cfg_cpol, "R1 idle sck level", int'(sck), int'(cfg_cpol));
    chk(cs_n == (fin ? 1'b1 : (active ? 1'b0 : 1'b1)), "R9 chip select after close",
        int'(cs_n), fin ? 1 : (active ? 0 : 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_cpol = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && busy === 1'b0 && done === 1'b0 && rx_valid === 1'b0,
        "R1 reset outputs", int'(cs_n), 1);
    chk(sck === 1'b1, "R1 idle sck follows cpol", int'(sck), 1);
    // sweep: all modes, three dividers, lengths 1..17
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 3; d++)
        for (int n = 1; n <= 17; n++)
          run_xfer(logic'(m[1]), logic'(m[0]), d, n, 1'b1, 1'b1, 1'b0);
    // R2 start during busy ignored
    run_xfer(1'b0, 1'b0, 1, 9, 1'b1, 1'b1, 1'b1);
    // R11 zero length, select held, then released
    run_xfer(1'b0, 1'b0, 1, 0, 1'b1, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b0, 1, 0, 1'b0, 1'b1, 1'b0);
    // R9 chained transaction keeps select low, slave stream continues
    run_xfer(1'b1, 1'b1, 0, 5, 1'b1, 1'b0, 1'b0);
    run_xfer(1'b1, 1'b1, 0, 11, 1'b0, 1'b1, 1'b0);
    // R9 no begin flag from released select
    run_xfer(1'b0, 1'b1, 0, 6, 1'b0, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule